// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A translation request arrives from the TLB side with the virtual address and the kind of access (load, store or instruction fetch). The walker captures the table root given by the process's table base, reads one first-level entry, then, only when that entry is present, reads one second-level (leaf) entry. It answers with the physical address, the leaf's rights bits and a status: translated, page fault or protection fault.

The virtual address is cut into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset (bits 11:0), so pages are 4 KB. Every table entry is one 32-bit word. An entry is present when bit 0 is 1 and its reserved bits 11:4 are all zero. Bits 31:12 of an entry are a frame number: in a first-level entry it is the page holding the second-level table, and in a leaf it is the physical page number. Leaf bit 1 grants read, bit 2 grants write and bit 3 grants execute.

Memory is reached through a read port that has one read in flight at a time: a request with valid/ready handshake, followed later by a one-cycle data return.

Top module: `pt_walker`

## Requirements
- R1: After a request is accepted, the first memory read goes to address base + 4 × (vaddr[31:22]), where base is the table root captured with the request.
- R2: The table root is sampled only in the cycle a request is accepted; changing `ptbr` while a walk runs has no effect on that walk's reads or result.
- R3: A first-level entry that is not present (bit 0 is 0, or any of bits 11:4 is 1) ends the walk after that single read with status 1 (page fault), `rsp_paddr` 0 and `rsp_rights` 0; no second read is issued.
- R4: For a present first-level entry E, the second read goes to address {E[31:12], 12'h000} + 4 × (vaddr[21:12]).
- R5: A leaf that is not present (same rule as R3) ends the walk with status 1, `rsp_paddr` 0 and `rsp_rights` 0.
- R6: Access code 0 (read) needs leaf bit 1, code 1 (write) needs bit 2, code 2 (execute) needs bit 3; a present leaf lacking the needed bit ends the walk with status 2 (protection fault), `rsp_paddr` 0 and `rsp_rights` = leaf[3:1].
- R7: Access code 3 is never permitted: a walk reaching a present leaf with code 3 ends with status 2.
- R8: A permitted access ends with status 0, `rsp_paddr` = {leaf[31:12], vaddr[11:0]} and `rsp_rights` = leaf[3:1] ({execute, write, read}).
- R9: A memory request keeps `mem_req_valid` high and its address unchanged until `mem_req_ready`, and no new request is raised until the previous read's data has returned.
- R10: `req_ready` is high only while idle; each accepted request yields exactly one response, `rsp_valid` high for a single cycle, after which `req_ready` is high again.
- R11: During and right after reset, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptbr | input | 32 | Root address of the current process's first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_rights | output | 3 | Leaf rights {execute, write, read} |
| rsp_status | output | 2 | 0 translated, 1 page fault, 2 protection fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Returned table entry |

## Verification
The assertions watch, on every cycle, the memory request handshake (a stalled request holds its address), the exclusion between a pending memory read, an idle walker and a response, the single-cycle response strobe, that a page fault clears address and rights, and that no status value 3 ever appears. Which entry addresses are read, how many reads a walk takes, the permission decision for each access kind, the final address assembly, and the root being captured only at acceptance can only be shown by the bench's walks against a table model, with memory stalls and varying return latency, switching table roots between walks and disturbing the root mid-walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [31:0]                           ptbr,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [L1_BITS+L2_BITS+OFF_BITS-1:0]   req_vaddr,
  input  logic [1:0]                            req_acc,
  output logic                                  rsp_valid,
  output logic [31:0]                           rsp_paddr,
  output logic [2:0]                            rsp_rights,
  output logic [1:0]                            rsp_status,
  output logic                                  mem_req_valid,
  input  logic                                  mem_req_ready,
  output logic [31:0]                           mem_req_addr,
  input  logic                                  mem_rsp_valid,
  input  logic [31:0]                           mem_rsp_data
);
  localparam int AW   = 32;
  localparam int VA_W = L1_BITS + L2_BITS + OFF_BITS;
  localparam int FW   = AW - OFF_BITS;
  localparam logic [1:0] ST_OK = 2'd0, ST_PF = 2'd1, ST_PROT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_L1_ADDR, S_L1_DATA, S_L2_ADDR, S_L2_DATA, S_RESP} state_t;

  state_t            st;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic [AW-1:0]     root_q;
  logic [FW-1:0]     tbl_q;
  logic [AW-1:0]     paddr_q;
  logic [2:0]        rights_q;
  logic [1:0]        status_q;

  wire [L1_BITS-1:0]  idx1 = va_q[VA_W-1 -: L1_BITS];
  wire [L2_BITS-1:0]  idx2 = va_q[OFF_BITS +: L2_BITS];
  wire [OFF_BITS-1:0] offs = va_q[OFF_BITS-1:0];

  wire [AW-1:0] l1_addr = root_q + {{(AW-L1_BITS-2){1'b0}}, idx1, 2'b00};
  wire [AW-1:0] l2_addr = {tbl_q, {OFF_BITS{1'b0}}} + {{(AW-L2_BITS-2){1'b0}}, idx2, 2'b00};

  wire present = mem_rsp_data[0] && (mem_rsp_data[OFF_BITS-1:4] == '0);

  logic perm_ok;
  always_comb begin
    case (acc_q)
      2'd0:    perm_ok = mem_rsp_data[1];
      2'd1:    perm_ok = mem_rsp_data[2];
      2'd2:    perm_ok = mem_rsp_data[3];
      default: perm_ok = 1'b0;
    endcase
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_L1_ADDR) || (st == S_L2_ADDR);
  assign mem_req_addr  = (st == S_L2_ADDR) ? l2_addr : l1_addr;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_rights    = rights_q;
  assign rsp_status    = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      acc_q    <= '0;
      root_q   <= '0;
      tbl_q    <= '0;
      paddr_q  <= '0;
      rights_q <= '0;
      status_q <= ST_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= req_acc;
          root_q <= ptbr;
          st     <= S_L1_ADDR;
        end
        S_L1_ADDR: if (mem_req_ready) st <= S_L1_DATA;
        S_L1_DATA: if (mem_rsp_valid) begin
          if (present) begin
            tbl_q <= mem_rsp_data[AW-1:OFF_BITS];
            st    <= S_L2_ADDR;
          end else begin
            paddr_q  <= '0;
            rights_q <= '0;
            status_q <= ST_PF;
            st       <= S_RESP;
          end
        end
        S_L2_ADDR: if (mem_req_ready) st <= S_L2_DATA;
        S_L2_DATA: if (mem_rsp_valid) begin
          st <= S_RESP;
          if (!present) begin
            paddr_q  <= '0;
            rights_q <= '0;
            status_q <= ST_PF;
          end else if (!perm_ok) begin
            paddr_q  <= '0;
            rights_q <= mem_rsp_data[3:1];
            status_q <= ST_PROT;
          end else begin
            paddr_q  <= {mem_rsp_data[AW-1:OFF_BITS], offs};
            rights_q <= mem_rsp_data[3:1];
            status_q <= ST_OK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready);

  assert_start_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req_valid && !req_ready);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  assert_fault_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == ST_PF |-> rsp_paddr == '0 && rsp_rights == '0);

  assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'd3);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_status;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_rights(rsp_rights), .rsp_status(rsp_status),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] addr_q [$];
  bit          exp_pending = 0;
  logic [31:0] exp_pa;
  logic [2:0]  exp_rt;
  logic [1:0]  exp_st;
  string       exp_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic bit is_present(input logic [31:0] e);
    return e[0] && (e[11:4] == 8'h00);
  endfunction

  // memory model, response checker, per-cycle comparison
  int          cyc = 0;
  bit          rd_pend = 0;
  int          rd_lat = 0;
  logic [31:0] rd_addr = '0;
  bit          prev_stall = 0;
  logic [31:0] prev_addr = '0;
  bit          prev_rsp = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R11",
          "idle outputs in reset", {req_ready, mem_req_valid, rsp_valid}, 3'b100);
    end else begin
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rd_pend) begin
        if (rd_lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(rd_addr);
          rd_pend = 0;
        end else rd_lat--;
      end
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9", "stalled request held",
            {mem_req_valid, mem_req_addr}, {1'b1, prev_addr});
      mem_req_ready = (cyc % 4) != 1;
      if (mem_req_valid) begin
        chk(!rd_pend && !mem_rsp_valid, "R9", "single outstanding read",
            {rd_pend, mem_rsp_valid}, 0);
        if (mem_req_ready) begin
          if (addr_q.size() == 0) begin
            chk(1'b0, exp_tag, "unexpected memory read", mem_req_addr, 0);
          end else begin
            chk(mem_req_addr == addr_q[0], (addr_q.size() == 2) ? "R1" : "R4",
                "entry address", mem_req_addr, addr_q[0]);
            void'(addr_q.pop_front());
          end
          rd_pend = 1;
          rd_addr = mem_req_addr;
          rd_lat  = cyc % 3;
        end
      end
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (rsp_valid) begin
        chk(!prev_rsp, "R10", "response longer than one cycle", 1, 0);
        if (!exp_pending) begin
          chk(1'b0, "R10", "spurious response", rsp_status, 0);
        end else begin
          chk(addr_q.size() == 0, exp_tag, "reads left unissued", addr_q.size(), 0);
          chk(rsp_status == exp_st, exp_tag, "status", rsp_status, exp_st);
          chk(rsp_paddr == exp_pa, exp_tag, "physical address", rsp_paddr, exp_pa);
          chk(rsp_rights == exp_rt, exp_tag, "rights", rsp_rights, exp_rt);
          exp_pending = 0;
        end
      end else if (prev_rsp) begin
        chk(req_ready, "R10", "ready after response", req_ready, 1);
      end
      prev_rsp = rsp_valid;
    end
  end

  task automatic walk(input logic [31:0] root, input logic [31:0] va,
                      input logic [1:0] acc, input string tag);
    logic [31:0] a1, e1, a2, e2;
    bit ok;
    a1 = root + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    addr_q.push_back(a1);
    exp_pa = '0; exp_rt = '0;
    if (!is_present(e1)) begin
      exp_st = 2'd1;
    end else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      addr_q.push_back(a2);
      e2 = rd(a2);
      if (!is_present(e2)) begin
        exp_st = 2'd1;
      end else begin
        ok = (acc == 2'd0) ? e2[1] : (acc == 2'd1) ? e2[2] : (acc == 2'd2) ? e2[3] : 1'b0;
        exp_rt = e2[3:1];
        if (ok) begin
          exp_st = 2'd0;
          exp_pa = {e2[31:12], va[11:0]};
        end else exp_st = 2'd2;
      end
    end
    exp_tag = tag;
    exp_pending = 1;
    @(negedge clk);
    chk(req_ready, "R10", "ready before request", req_ready, 1);
    req_valid = 1'b1; ptbr = root; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    ptbr = 32'hDEAD_0000;
    req_vaddr = 32'hFFFF_FFFF;
    req_acc = 2'd3;
    while (exp_pending) @(negedge clk);
  endtask

  localparam logic [31:0] ROOT_A = 32'h0010_0000;
  localparam logic [31:0] ROOT_B = 32'h0040_0000;

  function automatic logic [31:0] mkva(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  initial begin
    mem[ROOT_A + 3*4]        = {20'h00200, 12'h001};
    mem[32'h0020_0000 + 5*4] = {20'hABCDE, 12'h007};
    mem[32'h0020_0000 + 9*4] = {20'h12345, 12'h009};
    mem[32'h0020_0000 + 11*4] = {20'h55555, 12'h0F3};
    mem[ROOT_A + 8*4]        = {20'h00300, 12'h011};
    mem[32'h0030_0000 + 5*4] = {20'h77777, 12'h00F};
    mem[ROOT_B + 1023*4]     = {20'h00500, 12'h001};
    mem[32'h0050_0000 + 1023*4] = {20'hFEDCB, 12'h00F};
    mem[ROOT_B + 3*4]        = {20'h00600, 12'h001};
    mem[32'h0060_0000 + 5*4] = {20'h0BEEF, 12'h003};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    walk(ROOT_A, mkva(3, 5, 'h123), 2'd0, "R8");  // read on read/write page
    walk(ROOT_A, mkva(3, 5, 'h000), 2'd1, "R8");  // write
    walk(ROOT_A, mkva(3, 5, 'h456), 2'd2, "R6");  // execute denied
    walk(ROOT_A, mkva(7, 5, 'h010), 2'd0, "R3");  // absent first level
    walk(ROOT_A, mkva(3, 6, 'h010), 2'd0, "R5");  // absent leaf
    walk(ROOT_A, mkva(3, 5, 'h010), 2'd3, "R7");  // reserved access code
    walk(ROOT_A, mkva(3, 9, 'hABC), 2'd2, "R8");  // execute-only page
    walk(ROOT_A, mkva(3, 9, 'hABC), 2'd0, "R6");  // read on execute-only
    walk(ROOT_A, mkva(3, 9, 'hABC), 2'd1, "R6");  // write on execute-only
    walk(ROOT_A, mkva(8, 5, 'h001), 2'd0, "R3");  // reserved bits in first level
    walk(ROOT_A, mkva(3, 11, 'h001), 2'd0, "R5"); // reserved bits in leaf
    walk(ROOT_B, mkva(1023, 1023, 'hFFF), 2'd1, "R8"); // top-of-range indices
    walk(ROOT_B, mkva(3, 5, 'h123), 2'd0, "R2");  // same va, other process
    walk(ROOT_B, mkva(3, 5, 'h123), 2'd1, "R6");
    walk(ROOT_A, mkva(0, 0, 'h000), 2'd0, "R3");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule